// File: doc/BRIEF.md
# Multi-channel periodic interrupt timer

This peripheral holds four independent 32-bit down-counters. A processor reaches them through a single-cycle register port. Each channel counts down from a programmed load value. When it reaches zero it raises its flag, reloads itself and keeps running. No hardware one-shot exists, so software stops a channel by clearing its enable. Each channel drives its own interrupt line. That line is high when the channel's flag is set and its interrupt enable is on.

A channel above channel 0 can be put in chain mode. It then decrements once per expiry of the channel just below it. Two adjacent channels chained this way form a 64-bit timer. One module-level disable bit freezes every counter at once. A write to the load register never disturbs a running count. The new value is used at the next reload, or when the channel is stopped and started again.

Top module: `chain_tick_timer`

## Requirements
- R1: Byte addresses map as follows. The module control register is at 0x000, and its bit 1 is module disable. Channel n starts at 0x100 + 0x10*n, holding the load value at +0x0, the current value at +0x4, control at +0x8 and the flag at +0xC. Control bit 0 enables the timer, bit 1 enables the interrupt and bit 2 selects chain mode. The flag is bit 0 of its register.
- R2: After reset the module-disable bit reads 1, every channel register reads 0 and all interrupt outputs are low.
- R3: On the clock after the enable bit goes from 0 to 1, the current value is loaded from the load register. While the channel is disabled, its current value holds.
- R4: A running channel decrements by one per tick. A tick at zero sets the flag, reloads the load value and continues, so load L gives one expiry every L+1 clocks. Load 0 expires on every clock.
- R5: A load-register write to a running channel leaves the current count unchanged. The new value is used at the next reload.
- R6: While the module-disable bit is 1, no channel counts.
- R7: Writing 1 to flag bit 0 clears it and writing 0 leaves it unchanged. If an expiry and a clearing write happen in the same cycle, the flag stays set.
- R8: A channel's interrupt output is high exactly when its flag and its interrupt-enable bit are both 1.
- R9: In chain mode, channel n>0 decrements once per expiry of channel n-1. Chain mode on channel 0 has no effect, and channel 0 counts every clock.
- R10: The current-value register is read-only. Reads of unmapped or misaligned addresses return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, valid while bus_sel is high and bus_wr is low |
| irq | output | 4 | Per-channel interrupt request |

## Verification
The bench measures the count sequence for a table of load values, including load 0 and the first reload. A period that is off by one would show up as a wrong current value at the sampled cycle. It rewrites the load in mid-count. A design that copies the new value into the counter at once would then read back the new value instead of the continuing count. It clears a flag in the same cycle that a load-0 channel expires, which catches a clear that wins over the set. It steps a chained pair and checks chain mode on channel 0, which catch a chain that ticks every clock or a channel 0 that stalls. Finally it checks that the module-disable bit freezes counting and that writes to the current value or to unmapped addresses are dropped.

// File: rtl/ptimer_pkg.sv
`timescale 1ns/1ps
package ptimer_pkg;

    // Control register layout (bit 2 chain, bit 1 irq enable, bit 0 run)
    typedef struct packed {
        logic chain;
        logic irq_en;
        logic run_en;
    } ctl_t;

    // Register select within a channel window, word index of the offset
    typedef enum logic [1:0] {
        RG_LOAD = 2'd0,
        RG_CUR  = 2'd1,
        RG_CTL  = 2'd2,
        RG_FLAG = 2'd3
    } reg_sel_e;

    localparam int unsigned MCR_DIS_BIT = 1;
    localparam int unsigned CHAN_BASE   = 'h100;
    localparam int unsigned CHAN_STRIDE = 'h10;

    function automatic ctl_t to_ctl(input logic [2:0] bits);
        return ctl_t'(bits);
    endfunction

endpackage

// File: rtl/ptimer_decode.sv
`timescale 1ns/1ps
module ptimer_decode
    import ptimer_pkg::*;
#(
    parameter int unsigned AW  = 12,
    parameter int unsigned NCH = 4,
    localparam int unsigned CW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [AW-1:0] addr,
    output logic          is_mcr,
    output logic          is_chan,
    output logic [CW-1:0] ch_idx,
    output reg_sel_e      reg_sel
);
    localparam logic [AW-1:0] BASE  = AW'(CHAN_BASE);
    localparam logic [AW-1:0] LIMIT = AW'(CHAN_BASE + NCH * CHAN_STRIDE);

    logic [AW-1:0] off;

    always_comb begin
        off     = addr - BASE;
        is_mcr  = (addr == '0);
        is_chan = (addr >= BASE) && (addr < LIMIT) && (off[1:0] == 2'b00);
        ch_idx  = CW'(off >> 4);
        reg_sel = reg_sel_e'(off[3:2]);
    end
endmodule

// File: rtl/ptimer_channel.sv
`timescale 1ns/1ps
module ptimer_channel
    import ptimer_pkg::*;
#(
    parameter int unsigned DW    = 32,
    parameter bit          FIRST = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          mod_run,
    input  logic          prev_expire,
    input  logic          wr_load,
    input  logic          wr_ctl,
    input  logic          wr_flag,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] load_o,
    output logic [DW-1:0] cur_o,
    output ctl_t          ctl_o,
    output logic          flag_o,
    output logic          expire_o,
    output logic          irq_o
);
    ctl_t          ctl_q;
    logic          en_q;
    logic [DW-1:0] load_q;
    logic [DW-1:0] cur_q;
    logic          flag_q;
    logic          start;
    logic          tick;
    logic          active;

    always_comb begin
        start    = ctl_q.run_en & ~en_q;
        tick     = (FIRST || !ctl_q.chain) ? 1'b1 : prev_expire;
        active   = mod_run & ctl_q.run_en & ~start & tick;
        expire_o = active & (cur_q == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '0;
            en_q   <= 1'b0;
            load_q <= '0;
            cur_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            en_q <= ctl_q.run_en;
            if (wr_load) load_q <= wdata;
            if (wr_ctl)  ctl_q  <= to_ctl(wdata[2:0]);
            if (start)
                cur_q <= load_q;
            else if (active)
                cur_q <= (cur_q == '0) ? load_q : cur_q - 1'b1;
            if (expire_o)
                flag_q <= 1'b1;
            else if (wr_flag && wdata[0])
                flag_q <= 1'b0;
        end
    end

    assign load_o = load_q;
    assign cur_o  = cur_q;
    assign ctl_o  = ctl_q;
    assign flag_o = flag_q;
    assign irq_o  = flag_q & ctl_q.irq_en;

    // R4
    reload_chk: assert property (@(posedge clk) disable iff (rst)
        expire_o |=> (cur_q == $past(load_q)) && flag_q);

    // R3 R6
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!start && !(mod_run && ctl_q.run_en)) |=> $stable(cur_q));

    // R7
    w1c_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_flag && wdata[0] && !expire_o) |=> !flag_q);

    // R5
    load_nochg_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_load && active && cur_q != '0) |=> cur_q == $past(cur_q) - 1'b1);

endmodule

// File: rtl/chain_tick_timer.sv
`timescale 1ns/1ps
module chain_tick_timer
    import ptimer_pkg::*;
#(
    parameter int unsigned AW  = 12,
    parameter int unsigned DW  = 32,
    parameter int unsigned NCH = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           bus_sel,
    input  logic           bus_wr,
    input  logic [AW-1:0]  bus_addr,
    input  logic [DW-1:0]  bus_wdata,
    output logic [DW-1:0]  bus_rdata,
    output logic [NCH-1:0] irq
);
    localparam int unsigned CW = (NCH > 1) ? $clog2(NCH) : 1;

    logic          is_mcr;
    logic          is_chan;
    logic [CW-1:0] ch_idx;
    reg_sel_e      reg_sel;
    logic          mdis_q;
    logic          wr_any;

    logic [DW-1:0] ld_a  [NCH];
    logic [DW-1:0] cur_a [NCH];
    ctl_t          ctl_a [NCH];
    logic          flg_a [NCH];
    logic [NCH-1:0] exp_v;

    ptimer_decode #(.AW(AW), .NCH(NCH)) u_dec (
        .addr    (bus_addr),
        .is_mcr  (is_mcr),
        .is_chan (is_chan),
        .ch_idx  (ch_idx),
        .reg_sel (reg_sel)
    );

    assign wr_any = bus_sel & bus_wr;

    always_ff @(posedge clk) begin
        if (rst)
            mdis_q <= 1'b1;
        else if (wr_any && is_mcr)
            mdis_q <= bus_wdata[MCR_DIS_BIT];
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic sel_me;
        logic prev_exp;
        assign sel_me = wr_any & is_chan & (ch_idx == CW'(i));
        if (i == 0) begin : g_head
            assign prev_exp = 1'b0;
        end else begin : g_link
            assign prev_exp = exp_v[i-1];
        end
        ptimer_channel #(.DW(DW), .FIRST(i == 0)) u_ch (
            .clk         (clk),
            .rst         (rst),
            .mod_run     (~mdis_q),
            .prev_expire (prev_exp),
            .wr_load     (sel_me && reg_sel == RG_LOAD),
            .wr_ctl      (sel_me && reg_sel == RG_CTL),
            .wr_flag     (sel_me && reg_sel == RG_FLAG),
            .wdata       (bus_wdata),
            .load_o      (ld_a[i]),
            .cur_o       (cur_a[i]),
            .ctl_o       (ctl_a[i]),
            .flag_o      (flg_a[i]),
            .expire_o    (exp_v[i]),
            .irq_o       (irq[i])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            if (is_mcr) begin
                bus_rdata[MCR_DIS_BIT] = mdis_q;
            end else if (is_chan) begin
                case (reg_sel)
                    RG_LOAD: bus_rdata = ld_a[ch_idx];
                    RG_CUR:  bus_rdata = cur_a[ch_idx];
                    RG_CTL:  bus_rdata = DW'(ctl_a[ch_idx]);
                    RG_FLAG: bus_rdata = DW'(flg_a[ch_idx]);
                    default: bus_rdata = '0;
                endcase
            end
        end
    end

    // R10
    unmapped_rd_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr && bus_addr >= AW'(CHAN_BASE + NCH * CHAN_STRIDE))
            |-> bus_rdata == '0);

    // R6
    frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (mdis_q && $past(mdis_q)) |-> exp_v == '0);

endmodule

// File: tb/test_chain_tick_timer.sv
`timescale 1ns/1ps
module test_chain_tick_timer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    chain_tick_timer i_chain_tick_timer (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    function automatic logic [11:0] ra(input int ch, input int r);
        return 12'(256 + 16 * ch + 4 * r);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    localparam int NV = 9;
    localparam int TBL_L [NV] = '{3, 3, 3, 3, 0, 1, 1, 9, 255};
    localparam int TBL_K [NV] = '{1, 4, 5, 6, 5, 2, 7, 30, 10};

    initial begin
        #(8 * 100000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] x0;
        step(3);
        rst = 1'b0;
        step(1);

        // R2 reset state
        rd(12'h000, v); chk("R2 mcr", v, 32'h2);
        for (int c = 0; c < 4; c++) begin
            for (int r = 0; r < 4; r++) begin
                rd(ra(c, r), v); chk("R2 chan reg", v, 0);
            end
        end
        chk("R2 irq", 32'(irq), 0);

        // R6 module disabled: load on start, no counting. R1 offsets
        wr(ra(3, 0), 5);
        wr(ra(3, 2), 1);
        step(10);
        rd(ra(3, 1), v); chk("R6 frozen", v, 5);
        rd(ra(3, 0), v); chk("R1 load readback", v, 5);
        wr(12'h000, 0);
        step(3);
        rd(ra(3, 1), v); chk("R6 counts after enable", v, 2);
        rd(12'h000, v); chk("R1 mcr cleared", v, 0);
        wr(ra(3, 2), 0);

        // R4 R3 table of load values on channel 2
        for (int i = 0; i < NV; i++) begin
            int l;
            int k;
            l = TBL_L[i];
            k = TBL_K[i];
            wr(ra(2, 2), 0);
            wr(ra(2, 3), 1);
            wr(ra(2, 0), 32'(l));
            wr(ra(2, 2), 1);
            step(k);
            rd(ra(2, 1), v);
            chk("R4 cur", v, 32'(l - ((k - 1) % (l + 1))));
            rd(ra(2, 3), v);
            chk("R4 flag", v, (k >= l + 2) ? 1 : 0);
        end

        // R3 disabled channel holds
        wr(ra(2, 2), 0);
        rd(ra(2, 1), x0);
        step(5);
        rd(ra(2, 1), v); chk("R3 hold", v, x0);

        // R5 load write during run
        wr(ra(2, 0), 20);
        wr(ra(2, 2), 1);
        step(3);
        rd(ra(2, 1), v); chk("R5 pre", v, 18);
        wr(ra(2, 0), 6);
        rd(ra(2, 1), v); chk("R5 unchanged", v, 17);
        step(18);
        rd(ra(2, 1), v); chk("R5 new at reload", v, 6);
        step(7);
        rd(ra(2, 1), v); chk("R5 new period", v, 6);
        rd(ra(2, 3), v); chk("R4 flag set", v, 1);

        // R7 write-one-to-clear
        wr(ra(2, 2), 0);
        wr(ra(2, 3), 0);
        rd(ra(2, 3), v); chk("R7 write0 no effect", v, 1);
        wr(ra(2, 3), 1);
        rd(ra(2, 3), v); chk("R7 write1 clears", v, 0);

        // R8 interrupt gating, R7 set wins
        wr(ra(3, 0), 0);
        wr(ra(3, 3), 1);
        wr(ra(3, 2), 1);
        step(3);
        chk("R8 irq masked", 32'(irq[3]), 0);
        wr(ra(3, 2), 3);
        chk("R8 irq on", 32'(irq[3]), 1);
        wr(ra(3, 3), 1);
        rd(ra(3, 3), v); chk("R7 set wins", v, 1);
        wr(ra(3, 2), 0);
        wr(ra(3, 3), 1);
        chk("R8 irq off", 32'(irq[3]), 0);

        // R9 chaining channel 1 onto channel 0
        wr(ra(0, 2), 0);
        wr(ra(0, 0), 2);
        wr(ra(1, 0), 5);
        wr(ra(1, 2), 5);
        step(2);
        rd(ra(1, 1), v); chk("R9 chain idle", v, 5);
        wr(ra(0, 2), 1);
        step(10);
        rd(ra(1, 1), v); chk("R9 chain count", v, 2);
        rd(ra(1, 3), v); chk("R9 chain no flag", v, 0);
        step(9);
        rd(ra(1, 1), v); chk("R9 chain reload", v, 5);
        rd(ra(1, 3), v); chk("R9 chain flag", v, 1);
        wr(ra(0, 2), 0);
        wr(ra(0, 2), 5);
        step(3);
        rd(ra(0, 1), v); chk("R9 chain on ch0 ignored", v, 0);

        // R10 read-only current value and unmapped space
        wr(ra(0, 2), 0);
        rd(ra(0, 1), x0);
        wr(ra(0, 1), 32'hDEAD);
        rd(ra(0, 1), v); chk("R10 cur read-only", v, x0);
        wr(12'h140, 32'h55);
        rd(12'h140, v); chk("R10 unmapped read", v, 0);
        rd(12'h0FC, v); chk("R10 gap read", v, 0);
        rd(12'h102, v); chk("R10 misaligned read", v, 0);
        rd(ra(0, 0), v); chk("R10 load untouched", v, 2);
        rd(12'h000, v); chk("R10 mcr untouched", v, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule